// File: doc/BRIEF.md
# Byte-Register I2C Target

This block is an I2C target that lets an external bus controller read and write a file of 128 byte-wide registers. SCL and SDA are brought into the system clock domain and edge-detected there, so the system clock must run several times faster than the bus. The block recognises START, repeated START and STOP. It compares the incoming 7-bit device address against a fixed six-bit prefix plus one strap bit. It then takes a sub-address byte and moves bytes into or out of the register file.

A write transfer carries the device address with the direction bit clear, then the sub-address, then any number of data bytes. A read transfer writes the sub-address first, then issues a repeated START and the device address with the direction bit set. After that the target shifts out register bytes until the controller declines one. Bit 7 of the sub-address decides whether the register pointer steps after each data byte or stays where it is. The block drives SDA only as an open-drain pull-down enable.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling SDA while SCL is high is START and a rising SDA while SCL is high is STOP; bytes clocked while no START has been seen since reset or the last STOP are neither acknowledged nor acted on.
- R2: The device address is 7'b0011101 when `addr_lsb_i` is 1 and 7'b0011100 when it is 0; on a match the target acknowledges the address byte, whose bit 0 is 1 for read and 0 for write.
- R3: On an address mismatch the target leaves SDA released in the acknowledge slot and ignores all bytes until the next START, so a write sent to the wrong address leaves the registers unchanged.
- R4: Every byte the target receives (address, sub-address, data) is acknowledged by pulling SDA low for the whole high phase of the ninth SCL pulse; bytes are 8 bits, MSB first.
- R5: In a write, the byte after the address is the sub-address: bits 6..0 load the register pointer and bit 7 = 1 makes the pointer step by one after each data byte; each following data byte is stored at the pointer.
- R6: With sub-address bit 7 = 0 the pointer holds, so successive data bytes in a write overwrite one register and successive bytes in a read return the same register.
- R7: After a repeated START and the address with bit 0 = 1, the target sends the register at the pointer MSB first and, when the controller acknowledges and stepping is on, the next register after it.
- R8: A controller not-acknowledge on a read byte ends transmission: the target keeps SDA released for the rest of the transfer.
- R9: When stepping is on, the pointer wraps from 0x7F to 0x00.
- R10: A repeated START at any bit position abandons the byte in progress and restarts address reception; the register pointer keeps its value.
- R11: `sda_oe_o` changes only while the synchronised SCL is low, apart from being released on START and STOP.
- R12: Reset clears every register to 0x00 and deasserts `sda_oe_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, several times faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_lsb_i | input | 1 | Strap for the device address LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that the bus controller moves SDA only while SCL is low, except for the deliberate START and STOP edges. They also assume that every SCL phase lasts longer than the two-stage synchroniser delay, so that the edge order of the two lines survives the crossing. The stimulus keeps each SCL low phase at twelve system clocks and each high phase at ten. Data is changed halfway through the low phase, and SDA is released before every repeated START.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } slv_state_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CNT_W    = 4;
  localparam logic [3:0]  ACK_SLOT = 4'd8;
  localparam logic [3:0]  END_SLOT = 4'd9;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[i] <= '0;
      else if (we_i && (addr_i == AW'(i)))      mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_reg_pkg::*;
#(
  parameter int unsigned AW      = 7,
  parameter logic [5:0]  DEV_HI  = 6'b001110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_lsb_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              we_o,
  output logic [AW-1:0]     ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sda_oe_o
);
  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [AW-1:0]     ptr_q;
  logic              inc_q;
  logic              rw_q;
  logic              nack_q;
  logic              oe_q;
  logic              addr_hit;
  logic [AW-1:0]     ptr_step;

  assign addr_hit = (shift_q[7:1] == {DEV_HI, addr_lsb_i});
  assign ptr_step = ptr_q + AW'(inc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      inc_q   <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise_i) begin
            if (cnt_q < ACK_SLOT)  shift_q <= {shift_q[6:0], sda_lvl_i};
            if (cnt_q != END_SLOT) cnt_q   <= cnt_q + 1'b1;
          end
          if (scl_fall_i && cnt_q == ACK_SLOT) begin
            unique case (state_q)
              ST_ADDR: begin
                if (addr_hit) begin
                  oe_q <= 1'b1;
                  rw_q <= shift_q[0];
                end else begin
                  state_q <= ST_SKIP;
                end
              end
              ST_SUB: begin
                oe_q  <= 1'b1;
                ptr_q <= shift_q[AW-1:0];
                inc_q <= shift_q[7];
              end
              default: begin
                oe_q  <= 1'b1;
                ptr_q <= ptr_step;
              end
            endcase
          end
          if (scl_fall_i && cnt_q == END_SLOT) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
            unique case (state_q)
              ST_ADDR: begin
                if (rw_q) begin
                  state_q <= ST_RDATA;
                  shift_q <= rdata_i;
                  oe_q    <= ~rdata_i[7];
                  nack_q  <= 1'b0;
                end else begin
                  state_q <= ST_SUB;
                end
              end
              default: state_q <= ST_WDATA;
            endcase
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            if (cnt_q == ACK_SLOT) begin
              if (sda_lvl_i) nack_q <= 1'b1;
              else           ptr_q  <= ptr_step;
            end
            if (cnt_q != END_SLOT) cnt_q <= cnt_q + 1'b1;
          end
          if (scl_fall_i) begin
            if (cnt_q != '0 && cnt_q < ACK_SLOT) begin
              shift_q <= {shift_q[6:0], 1'b1};
              oe_q    <= ~shift_q[6];
            end else if (cnt_q == ACK_SLOT) begin
              oe_q <= 1'b0;
            end else if (cnt_q == END_SLOT) begin
              cnt_q <= '0;
              if (nack_q) begin
                state_q <= ST_SKIP;
                oe_q    <= 1'b0;
              end else begin
                shift_q <= rdata_i;
                oe_q    <= ~rdata_i[7];
              end
            end
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign we_o     = !start_i && !stop_i && state_q == ST_WDATA
                    && scl_fall_i && cnt_q == ACK_SLOT;
  assign ptr_o    = ptr_q;
  assign wdata_o  = shift_q;
  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_HI      = 6'b001110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_lsb_i,
  output logic sda_oe_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_lvl, line_rise, line_fall;
  logic               scl_lvl, scl_rise, scl_fall, sda_lvl;
  logic               start_det, stop_det;
  logic               we;
  logic [ADDR_W-1:0]  ptr;
  logic [BYTE_W-1:0]  wdata, rdata;

  assign line_raw = {sda_i, scl_i};

  for (genvar l = 0; l < N_LINES; l++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_raw[l]),
      .lvl_o  (line_lvl[l]),
      .rise_o (line_rise[l]),
      .fall_o (line_fall[l])
    );
  end

  assign scl_lvl   = line_lvl[0];
  assign scl_rise  = line_rise[0];
  assign scl_fall  = line_fall[0];
  assign sda_lvl   = line_lvl[1];
  assign start_det = line_fall[1] & scl_lvl;
  assign stop_det  = line_rise[1] & scl_lvl;

  i2c_slave_fsm #(.AW(ADDR_W), .DEV_HI(DEV_HI)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .addr_lsb_i (addr_lsb_i),
    .rdata_i    (rdata),
    .we_o       (we),
    .ptr_o      (ptr),
    .wdata_o    (wdata),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_reg_file #(.AW(ADDR_W), .DW(BYTE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (ptr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int unsigned AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_lvl,
  input logic          start_det,
  input logic          stop_det,
  input logic [AW-1:0] ptr,
  input logic          sda_oe_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det))) // R11
    else $error("oe moved while SCL high");

  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o) // R11
    else $error("oe held after START");

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o) // R11
    else $error("oe held after STOP");

  AST_PTR_KEEP_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (ptr == $past(ptr))) // R10
    else $error("pointer lost on START");

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_RELEASE: assert (!sda_oe_o) // R12
        else $error("oe active in reset");
    end
  end
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_lvl   (scl_lvl),
  .start_det (start_det),
  .stop_det  (stop_det),
  .ptr       (ptr),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int Q = 6;
  localparam int H = 10;
  localparam logic [6:0] DEV_A = 7'h1D;
  localparam logic [6:0] DEV_B = 7'h1C;

  typedef struct packed {
    logic [6:0] reg_a;
    logic [7:0] val;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h00, 8'h5A}, '{7'h01, 8'hA5}, '{7'h7F, 8'hFF},
    '{7'h3C, 8'h80}, '{7'h12, 8'h01}, '{7'h66, 8'h3E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int n_chk = 0;
  int n_bad = 0;
  int oe_viol = 0;
  bit done = 0;

  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .addr_lsb_i (strap),
    .sda_oe_o   (sda_oe)
  );

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; hc(H);
    sda_m = 1'b0; hc(H);
    scl_m = 1'b0; hc(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; hc(Q);
    scl_m = 1'b1; hc(H);
    sda_m = 1'b0; hc(H);
    scl_m = 1'b0; hc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hc(Q);
    scl_m = 1'b1; hc(H);
    sda_m = 1'b1; hc(H);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; hc(Q);
    scl_m = 1'b1; hc(H);
    scl_m = 1'b0; hc(Q);
  endtask

  task automatic write_byte(logic [7:0] b, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; hc(Q);
    scl_m = 1'b1; hc(2);
    a1 = sda_bus; hc(H-2);
    a2 = sda_bus;
    scl_m = 1'b0; hc(Q);
    ack = !a1 && !a2;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mak);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hc(2*Q);
      scl_m = 1'b1; hc(H/2);
      b = {b[6:0], sda_bus}; hc(H/2);
      scl_m = 1'b0;
    end
    hc(Q);
    sda_m = !mak; hc(Q);
    scl_m = 1'b1; hc(H);
    scl_m = 1'b0; hc(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_xfer(logic [6:0] dev, logic [7:0] sub, int n, output logic ack_a);
    logic ak;
    bus_start();
    write_byte({dev, 1'b0}, ack_a);
    write_byte(sub, ak);
    for (int i = 0; i < n; i++) write_byte(wbuf[i], ak);
    bus_stop();
  endtask

  task automatic rd_xfer(logic [6:0] dev, logic [7:0] sub, int n);
    logic ak;
    bus_start();
    write_byte({dev, 1'b0}, ak);
    write_byte(sub, ak);
    bus_rstart();
    write_byte({dev, 1'b1}, ak);
    for (int i = 0; i < n; i++) read_byte(rbuf[i], i != n - 1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] b;
    hc(5);
    chk("R12 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    hc(5);

    // R12: register contents after reset
    rd_xfer(DEV_A, 8'h10, 1);
    chk("R12 reset value", rbuf[0], 8'h00);

    // vector table: single write then read back
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VECS[v].val;
      wr_xfer(DEV_A, {1'b0, VECS[v].reg_a}, 1, ak);
      chk("R2 R4 address ack", ak, 1);
      rd_xfer(DEV_A, {1'b0, VECS[v].reg_a}, 1);
      chk("R5 R7 read back", rbuf[0], VECS[v].val);
    end

    // strap low
    strap = 1'b0;
    wbuf[0] = 8'hA5;
    wr_xfer(DEV_B, 8'h50, 1, ak);
    chk("R2 strap low ack", ak, 1);
    wbuf[0] = 8'h11;
    wr_xfer(DEV_A, 8'h50, 1, ak);
    chk("R3 mismatch no ack", ak, 0);
    rd_xfer(DEV_B, 8'h50, 1);
    chk("R3 write ignored", rbuf[0], 8'hA5);
    strap = 1'b1;

    // stepping burst
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_xfer(DEV_A, 8'hA0, 3, ak);
    rd_xfer(DEV_A, 8'hA0, 3);
    chk("R5 R7 burst 0", rbuf[0], 8'h11);
    chk("R5 R7 burst 1", rbuf[1], 8'h22);
    chk("R5 R7 burst 2", rbuf[2], 8'h33);

    // fixed pointer
    wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    wr_xfer(DEV_A, 8'h30, 3, ak);
    rd_xfer(DEV_A, 8'h30, 1);
    chk("R6 fixed write last", rbuf[0], 8'h66);
    rd_xfer(DEV_A, 8'h31, 1);
    chk("R6 neighbour untouched", rbuf[0], 8'h00);
    rd_xfer(DEV_A, 8'h20, 2);
    chk("R6 fixed read 0", rbuf[0], 8'h11);
    chk("R6 fixed read 1", rbuf[1], 8'h11);

    // wrap
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    wr_xfer(DEV_A, 8'hFF, 2, ak);
    rd_xfer(DEV_A, 8'h7F, 1);
    chk("R9 last register", rbuf[0], 8'h77);
    rd_xfer(DEV_A, 8'h00, 1);
    chk("R9 wrapped register", rbuf[0], 8'h88);

    // NACK ends transmission
    bus_start();
    write_byte({DEV_A, 1'b0}, ak);
    write_byte(8'hA0, ak);
    bus_rstart();
    write_byte({DEV_A, 1'b1}, ak);
    read_byte(b, 1'b0);
    chk("R8 byte before nack", b, 8'h11);
    read_byte(b, 1'b0);
    chk("R8 silent after nack", b, 8'hFF);
    bus_stop();
    chk("R11 released after stop", sda_oe, 0);

    // R1: no START, bytes ignored
    write_byte({DEV_A, 1'b0}, ak);
    chk("R1 idle bus no ack", ak, 0);
    bus_stop();

    // R10: repeated START mid-byte keeps pointer
    wbuf[0] = 8'h9C;
    wr_xfer(DEV_A, 8'h45, 1, ak);
    bus_start();
    write_byte({DEV_A, 1'b0}, ak);
    write_byte(8'h45, ak);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bus_rstart();
    chk("R11 released after start", sda_oe, 0);
    write_byte({DEV_A, 1'b1}, ak);
    chk("R10 address after abort", ak, 1);
    read_byte(b, 1'b0);
    chk("R10 pointer kept", b, 8'h9C);
    bus_stop();

    chk("R11 oe moved with SCL high", oe_viol, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule